// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the operand address for a small processor core with 16-bit addresses and byte or word operands. The decoder presents a mode code, the selected general register, the operand size, the instruction's extension field and the current program counter, together with a one-cycle `start_i` strobe. One cycle later the block returns the effective address with a `done_o` pulse. In the auto-step modes it also returns the updated register value and a write-back enable.

Seven of the eight modes finish in that single cycle. The memory-indirect mode instead raises a read request for a pointer word. It holds the request until the memory answers, and returns the fetched word as the effective address one cycle after the answer. Word operands on an odd address raise an alignment flag, and that flag blocks the register write-back.

Top module: `opaddr_gen`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `wb_en_o`, `rd_req_o`, `align_err_o` and `ea_o` are all 0. A start is accepted from the fourth rising edge after `rst_ni` rises.
- R2: Mode code 0 (register indirect): one cycle after an accepted start, `done_o` is 1 and `ea_o` equals `reg_i`.
- R3: Mode code 1 (register plus displacement): `ea_o` equals `reg_i + field_i`, modulo 2^16.
- R4: Mode code 2 (step after access): `ea_o` equals `reg_i` and `wb_val_o` equals `reg_i + step`. The step is 1 when `word_i`=0 (byte) and 2 when `word_i`=1 (word).
- R5: Mode code 3 (step before access): `ea_o` and `wb_val_o` both equal `reg_i - step`, modulo 2^16, with the same step as in R4.
- R6: Mode code 4 (short absolute) gives `ea_o` = {8'hFF, `field_i[7:0]`}. Mode code 5 (long absolute) gives `ea_o` = `field_i`.
- R7: Mode code 6 (PC-relative) gives `ea_o` = `pc_i` plus the sign-extended `field_i[7:0]`, modulo 2^16.
- R8: Mode code 7 (memory indirect): in the cycle after the start, `rd_req_o` is 1 with `rd_addr_o` = {8'h00, `field_i[7:0]`}. The request stays high until a cycle with `rd_valid_i`=1. In the next cycle `rd_req_o` is 0, `done_o` is 1 and `ea_o` equals the `rd_data_i` of that cycle.
- R9: With `done_o`, `align_err_o` is 1 exactly when `word_i` was 1 and `ea_o[0]` is 1. It is never set for byte operands. In modes 2 and 3 this is the same as testing bit 0 of the original register.
- R10: `wb_en_o` pulses together with `done_o` only in modes 2 and 3, and only when `align_err_o` is 0.
- R11: While a pointer fetch is pending, `start_i` is ignored. No `done_o` appears before the fetch completes, and the result is the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| mode_i | input | 3 | Addressing mode code |
| word_i | input | 1 | Operand size: 1 = word, 0 = byte |
| reg_i | input | 16 | Selected general register value |
| field_i | input | 16 | Displacement or absolute field from the instruction |
| pc_i | input | 16 | Current program counter |
| rd_valid_i | input | 1 | Pointer read response valid |
| rd_data_i | input | 16 | Pointer read response word |
| ea_o | output | 16 | Effective address |
| done_o | output | 1 | Result valid pulse |
| align_err_o | output | 1 | Word operand on odd address |
| wb_en_o | output | 1 | Register write-back enable pulse |
| wb_val_o | output | 16 | Register write-back value |
| rd_req_o | output | 1 | Pointer read request, held until answered |
| rd_addr_o | output | 16 | Pointer read address |

## Verification
The assertions assume that `start_i` is low during reset and during the synchronizer cycles after it. They also assume that `rd_valid_i` counts only while `rd_req_o` is high, since the fetch rule relates the response cycle to the following result. The stimulus applies starts only after the reset wait and raises `rd_valid_i` only during a pending request, for one cycle. Inputs change only on falling edges, and the ignored starts issued during a fetch are the only starts that meet a busy block.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  typedef enum logic [2:0] {
    AM_REG_IND   = 3'd0,
    AM_REG_DISP  = 3'd1,
    AM_POST_INC  = 3'd2,
    AM_PRE_DEC   = 3'd3,
    AM_ABS_SHORT = 3'd4,
    AM_ABS_LONG  = 3'd5,
    AM_PC_REL    = 3'd6,
    AM_MEM_IND   = 3'd7
  } amode_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_WAIT = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/opaddr_calc.sv
module opaddr_calc
  import opaddr_pkg::*;
#(
  parameter int AW = 16,
  parameter int SW = 8,
  parameter logic [AW-SW-1:0] HIGH_PAGE = '1
) (
  input  amode_e        mode_i,
  input  logic          word_i,
  input  logic [AW-1:0] reg_i,
  input  logic [AW-1:0] field_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] step_o,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] ptr_o
);
  localparam int XW = AW - SW;

  logic [AW-1:0] short_sext;
  logic [AW-1:0] short_page;

  always_comb begin
    step_o     = word_i ? AW'(2) : AW'(1);
    short_sext = {{XW{field_i[SW-1]}}, field_i[SW-1:0]};
    short_page = {HIGH_PAGE, field_i[SW-1:0]};
    ptr_o      = {{XW{1'b0}}, field_i[SW-1:0]};
    case (mode_i)
      AM_REG_IND:   ea_o = reg_i;
      AM_REG_DISP:  ea_o = reg_i + field_i;
      AM_POST_INC:  ea_o = reg_i;
      AM_PRE_DEC:   ea_o = reg_i - step_o;
      AM_ABS_SHORT: ea_o = short_page;
      AM_ABS_LONG:  ea_o = field_i;
      AM_PC_REL:    ea_o = pc_i + short_sext;
      default:      ea_o = ptr_o;
    endcase
  end
endmodule

// File: rtl/opaddr_step.sv
module opaddr_step
  import opaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input  amode_e        mode_i,
  input  logic [AW-1:0] reg_i,
  input  logic [AW-1:0] step_i,
  output logic          wb_req_o,
  output logic [AW-1:0] wb_val_o
);
  always_comb begin
    wb_req_o = (mode_i == AM_POST_INC) || (mode_i == AM_PRE_DEC);
    if (mode_i == AM_POST_INC) begin
      wb_val_o = reg_i + step_i;
    end else begin
      wb_val_o = reg_i - step_i;
    end
  end
endmodule

// File: rtl/opaddr_fetch.sv
module opaddr_fetch
  import opaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          word_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          rd_valid_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          fin_o,
  output logic          fin_word_o
);
  fetch_state_e state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          word_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      FS_IDLE: if (launch_i)   state_d = FS_WAIT;
      default: if (rd_valid_i) state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      word_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch_i) begin
        addr_q <= ptr_i;
        word_q <= word_i;
      end
    end
  end

  assign rd_req_o   = (state_q == FS_WAIT);
  assign rd_addr_o  = addr_q;
  assign fin_o      = rd_req_o && rd_valid_i;
  assign fin_word_o = word_q;
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int AW = 16,
  parameter int SW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic          word_i,
  input  logic [AW-1:0] reg_i,
  input  logic [AW-1:0] field_i,
  input  logic [AW-1:0] pc_i,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_data_i,
  output logic [AW-1:0] ea_o,
  output logic          done_o,
  output logic          align_err_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o
);
  localparam int SMSB = SYNC_STAGES - 1;

  logic [SMSB:0] sync_q;
  logic          rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SMSB-1:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SMSB];

  amode_e        mode;
  logic [AW-1:0] step, calc_ea, ptr, wb_val_c;
  logic          wb_req, fin, fin_word;

  assign mode = amode_e'(mode_i);

  opaddr_calc #(.AW(AW), .SW(SW)) u_calc (
    .mode_i(mode), .word_i(word_i), .reg_i(reg_i), .field_i(field_i),
    .pc_i(pc_i), .step_o(step), .ea_o(calc_ea), .ptr_o(ptr)
  );

  opaddr_step #(.AW(AW)) u_step (
    .mode_i(mode), .reg_i(reg_i), .step_i(step),
    .wb_req_o(wb_req), .wb_val_o(wb_val_c)
  );

  logic take, single, launch;

  opaddr_fetch #(.AW(AW)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .launch_i(launch), .word_i(word_i),
    .ptr_i(ptr), .rd_valid_i(rd_valid_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .fin_o(fin), .fin_word_o(fin_word)
  );

  logic [AW-1:0] ea_d;
  logic          ea_en, err_d, wb_en_d;
  logic [AW-1:0] ea_q, wb_val_q;
  logic          done_q, err_q, wb_en_q;

  always_comb begin
    take    = start_i && !rd_req_o;
    single  = take && (mode != AM_MEM_IND);
    launch  = take && (mode == AM_MEM_IND);
    ea_en   = single || fin;
    ea_d    = single ? calc_ea : rd_data_i;
    err_d   = (single ? word_i : fin_word) && ea_d[0];
    wb_en_d = single && wb_req && !err_d;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ea_q     <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      wb_en_q  <= 1'b0;
      wb_val_q <= '0;
    end else begin
      done_q  <= ea_en;
      wb_en_q <= wb_en_d;
      if (ea_en) begin
        ea_q  <= ea_d;
        err_q <= err_d;
      end
      if (single) wb_val_q <= wb_val_c;
    end
  end

  assign ea_o        = ea_q;
  assign done_o      = done_q;
  assign align_err_o = err_q;
  assign wb_en_o     = wb_en_q;
  assign wb_val_o    = wb_val_q;
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk
  import opaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          start_i,
  input logic [2:0]    mode_i,
  input logic          word_i,
  input logic [AW-1:0] reg_i,
  input logic          rd_valid_i,
  input logic [AW-1:0] rd_data_i,
  input logic [AW-1:0] ea_o,
  input logic          done_o,
  input logic          align_err_o,
  input logic          wb_en_o,
  input logic [AW-1:0] wb_val_o,
  input logic          rd_req_o
);
  assert_single_done_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i && !rd_req_o && (mode_i != AM_MEM_IND) |=> done_o);

  assert_regind_ea_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i && !rd_req_o && (mode_i == AM_REG_IND) |=> ea_o == $past(reg_i));

  assert_post_step_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i && !rd_req_o && (mode_i == AM_POST_INC) |=>
      (ea_o == $past(reg_i)) &&
      (wb_val_o == $past(reg_i) + ($past(word_i) ? AW'(2) : AW'(1))));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_req_o && !rd_valid_i |=> rd_req_o);

  assert_ind_result_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_req_o && rd_valid_i |=> done_o && !rd_req_o && !wb_en_o &&
      (ea_o == $past(rd_data_i)));

  assert_byte_clean_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i && !rd_req_o && (mode_i != AM_MEM_IND) && !word_i |=> !align_err_o);

  assert_wb_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    wb_en_o |-> done_o && !align_err_o);

  assert_busy_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_req_o && !rd_valid_i |=> !done_o);
endmodule

bind opaddr_gen opaddr_gen_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_n(rst_sync_n), .start_i(start_i), .mode_i(mode_i),
  .word_i(word_i), .reg_i(reg_i), .rd_valid_i(rd_valid_i),
  .rd_data_i(rd_data_i), .ea_o(ea_o), .done_o(done_o),
  .align_err_o(align_err_o), .wb_en_o(wb_en_o), .wb_val_o(wb_val_o),
  .rd_req_o(rd_req_o)
);

// File: tb/opaddr_gen_tb.sv
`timescale 1ns/1ps
module opaddr_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i, word_i, rd_valid_i;
  logic [2:0]  mode_i;
  logic [15:0] reg_i, field_i, pc_i, rd_data_i;
  logic [15:0] ea_o, wb_val_o, rd_addr_o;
  logic        done_o, align_err_o, wb_en_o, rd_req_o;

  int nchk = 0;
  int nerr = 0;
  bit ended = 0;

  always #2 clk_i = ~clk_i;

  opaddr_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .word_i(word_i), .reg_i(reg_i), .field_i(field_i), .pc_i(pc_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .ea_o(ea_o),
    .done_o(done_o), .align_err_o(align_err_o), .wb_en_o(wb_en_o),
    .wb_val_o(wb_val_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o)
  );

  logic [15:0] rv [8] = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF,
                          16'hFFFE, 16'h7FFF, 16'h8000, 16'h1235};
  logic [15:0] fv [6] = '{16'h0000, 16'h007F, 16'h0080, 16'h00FF,
                          16'hFFFF, 16'h1234};
  logic [15:0] pv [2] = '{16'h0100, 16'hFFF0};

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ea(int m, bit w, logic [15:0] r,
                                         logic [15:0] f, logic [15:0] p);
    logic [15:0] s;
    s = w ? 16'd2 : 16'd1;
    case (m)
      0: return r;
      1: return r + f;
      2: return r;
      3: return r - s;
      4: return {8'hFF, f[7:0]};
      5: return f;
      default: return p + {{8{f[7]}}, f[7:0]};
    endcase
  endfunction

  function automatic logic [15:0] mem_word(logic [15:0] a);
    return {a[7:0] ^ 8'hC3, ~a[7:0]};
  endfunction

  function automatic string tag(int m);
    case (m)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R6"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic run_single(int m, bit w, logic [15:0] r, logic [15:0] f,
                            logic [15:0] p);
    logic [15:0] e, s, wv;
    bit err, step_mode;
    s = w ? 16'd2 : 16'd1;
    e = exp_ea(m, w, r, f, p);
    err = w && e[0];
    step_mode = (m == 2) || (m == 3);
    wv = (m == 2) ? r + s : r - s;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 3'(m); word_i = w;
    reg_i = r; field_i = f; pc_i = p;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b1, tag(m), {15'd0, done_o}, 16'd1);
    chk(ea_o == e, tag(m), ea_o, e);
    chk(align_err_o == err, "R9", {15'd0, align_err_o}, {15'd0, err});
    chk(wb_en_o == (step_mode && !err), "R10", {15'd0, wb_en_o},
        {15'd0, step_mode && !err});
    if (step_mode) chk(wb_val_o == wv, tag(m), wb_val_o, wv);
  endtask

  task automatic run_indirect(bit w, logic [15:0] f, int delay);
    logic [15:0] pa, d;
    bit err;
    pa = {8'h00, f[7:0]};
    d = mem_word(pa);
    err = w && d[0];
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 3'd7; word_i = w; field_i = f;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(rd_req_o == 1'b1, "R8", {15'd0, rd_req_o}, 16'd1);
    chk(rd_addr_o == pa, "R8", rd_addr_o, pa);
    for (int k = 0; k < delay; k++) begin
      start_i = 1'b1; mode_i = 3'd5; field_i = 16'hBEEF; word_i = 1'b0;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R11", {15'd0, done_o}, 16'd0);
      chk(rd_req_o == 1'b1, "R8", {15'd0, rd_req_o}, 16'd1);
    end
    rd_valid_i = 1'b1; rd_data_i = d;
    @(negedge clk_i);
    rd_valid_i = 1'b0; rd_data_i = 16'h0000;
    chk(done_o == 1'b1, "R8", {15'd0, done_o}, 16'd1);
    chk(rd_req_o == 1'b0, "R8", {15'd0, rd_req_o}, 16'd0);
    chk(ea_o == d, (delay > 0) ? "R11" : "R8", ea_o, d);
    chk(align_err_o == err, "R9", {15'd0, align_err_o}, {15'd0, err});
    chk(wb_en_o == 1'b0, "R10", {15'd0, wb_en_o}, 16'd0);
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; mode_i = 3'd0; word_i = 1'b0;
    reg_i = '0; field_i = '0; pc_i = '0; rd_valid_i = 1'b0; rd_data_i = '0;
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0, "R1", {15'd0, done_o}, 16'd0);
    chk(wb_en_o == 1'b0, "R1", {15'd0, wb_en_o}, 16'd0);
    chk(rd_req_o == 1'b0, "R1", {15'd0, rd_req_o}, 16'd0);
    chk(align_err_o == 1'b0, "R1", {15'd0, align_err_o}, 16'd0);
    chk(ea_o == 16'h0000, "R1", ea_o, 16'h0000);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    for (int m = 0; m < 8; m++)
      for (int w = 0; w < 2; w++)
        for (int ri = 0; ri < 8; ri++)
          for (int fi = 0; fi < 6; fi++)
            for (int pi = 0; pi < 2; pi++) begin
              if (m == 7) run_indirect(w[0], fv[fi] ^ rv[ri], (ri + fi + pi) % 4);
              else        run_single(m, w[0], rv[ri], fv[fi], pv[pi]);
            end
    @(negedge clk_i);
    chk(done_o == 1'b0, "R2", {15'd0, done_o}, 16'd0);
    chk(wb_en_o == 1'b0, "R10", {15'd0, wb_en_o}, 16'd0);
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule